// File: doc/BRIEF.md
# Offline Supply Startup Protection Sequencer

This block is the digital supervisor of a single-die offline switching regulator. Comparators and sensors outside the block reduce the analog world to a few flags: the supply has reached its start level, the supply has sagged below its lockout level, the supply is above its overvoltage limit, the mains-sense input is above its reference, and the internal reference is within its window. A separate unsigned code carries the die temperature. From these inputs the sequencer decides when the high-voltage start-up current source charges the supply capacitor, when the pulse-width modulator may switch the power transistor, when the gate is clamped low, and when the rest of the controller logic receives a reset.

Power-up passes through three states: lockout, a one-cycle reset, and run. Overvoltage is a latched fault. Once it has been seen, switching stays off until the supply collapses into lockout, so an auxiliary-winding runaway turns into hiccup operation. Low mains and over-temperature are not latched. They only gate the modulator, and it resumes as soon as the condition clears. While switching is gated off, the supply drains and the block falls back into lockout, so the start-up source recharges the supply and the supply cycles between the two thresholds. Hysteresis on the mains-sense input comes from a current source that the block switches on only while that input is above its reference. The temperature flag uses separate trip and release codes as its hysteresis band.

Top module: `offsup_seq`

## Requirements
- R1: In the lockout state `startup_en`=1, `gate_pulldown`=1 and `pwm_en`=0.
- R2: Lockout is left only in a cycle where `vcc_above_start`=1, `vcc_below_uvlo`=0 and `ref_ok`=1. The next state is a reset state in which `logic_rst`=1 for exactly one cycle, with `pwm_en`=0 and `startup_en` still 1. The cycle after that is the run state.
- R3: In the run state `startup_en`=0 and `gate_pulldown`=0. With no fault present, `pwm_en`=1.
- R4: In the reset or run state, `vcc_below_uvlo`=1 or `ref_ok`=0 returns the block to lockout at the next clock edge.
- R5: `vcc_over_limit`=1 forces `pwm_en`=0 in the same cycle and sets a latch at the next edge. While the latch is set, `pwm_en` stays 0 even after the input returns low. Only the lockout state clears the latch.
- R6: `bo_above_ref`=0 forces `pwm_en`=0 combinationally, with no latching. `pwm_en` returns as soon as the input is 1 again, and the state is unaffected.
- R7: `bo_hyst_en` equals `bo_above_ref` in every state.
- R8: A registered thermal flag sets when `temp_code` >= TRIP_CODE and clears when `temp_code` <= RELEASE_CODE. Between the two codes it keeps its value. The flag updates at the clock edge that samples the code. While the flag is set, `pwm_en`=0.
- R9: While `rst_n`=0 the block is in lockout with the overvoltage latch and the thermal flag clear, and `logic_rst`=0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_above_start | input | 1 | Supply at or above the start threshold |
| vcc_below_uvlo | input | 1 | Supply below the lockout threshold |
| vcc_over_limit | input | 1 | Supply above the overvoltage limit |
| bo_above_ref | input | 1 | Mains-sense input above its reference |
| ref_ok | input | 1 | Internal reference within its window |
| temp_code | input | TEMP_W | Unsigned die-temperature code |
| startup_en | output | 1 | Enable for the high-voltage start-up current source |
| pwm_en | output | 1 | Permission for the modulator to switch |
| gate_pulldown | output | 1 | Clamp that holds the power-transistor gate low |
| bo_hyst_en | output | 1 | Enable for the mains-sense hysteresis current |
| logic_rst | output | 1 | One-cycle reset pulse to the controller logic |

## Verification
The bench builds the block with TEMP_W=4, TRIP_CODE=12 and RELEASE_CODE=8. With these values a ramp up and back down over the full code range visits every code in both directions. That covers both edges of the hysteresis band and the hold region between them. All eight combinations of the start, lockout and reference flags are applied from lockout, which covers every exit condition. Directed sequences then exercise overvoltage latching and its clearing, mains-sense gating and a reference drop from the run state.

// File: rtl/offsup_pkg.sv
package offsup_pkg;

  typedef enum logic [1:0] {
    SQ_LOCK = 2'd0,
    SQ_RST  = 2'd1,
    SQ_RUN  = 2'd2
  } sq_state_t;

  // Hysteretic comparison of a temperature code against trip/release codes.
  function automatic logic therm_next(input logic cur, input logic [15:0] code,
                                      input logic [15:0] trip, input logic [15:0] rel);
    if (code >= trip)      return 1'b1;
    else if (code <= rel)  return 1'b0;
    else                   return cur;
  endfunction

endpackage

// File: rtl/offsup_fsm.sv
module offsup_fsm
  import offsup_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      can_start,
  input  logic      must_drop,
  output sq_state_t state
);

  sq_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      SQ_LOCK: if (can_start) nxt = SQ_RST;
      SQ_RST:  nxt = must_drop ? SQ_LOCK : SQ_RUN;
      SQ_RUN:  if (must_drop) nxt = SQ_LOCK;
      default: nxt = SQ_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_LOCK;
    else        state <= nxt;
  end

endmodule

// File: rtl/offsup_ovp_latch.sv
module offsup_ovp_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (set) q <= 1'b1;
  end

endmodule

// File: rtl/offsup_therm.sv
module offsup_therm
  import offsup_pkg::*;
#(
  parameter int TEMP_W       = 8,
  parameter int TRIP_CODE    = 150,
  parameter int RELEASE_CODE = 110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] code,
  output logic              hot
);

  localparam logic [15:0] TRIP16 = 16'(TRIP_CODE);
  localparam logic [15:0] REL16  = 16'(RELEASE_CODE);

  logic [15:0] code16;
  assign code16 = 16'(code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot <= 1'b0;
    else        hot <= therm_next(hot, code16, TRIP16, REL16);
  end

endmodule

// File: rtl/offsup_seq.sv
module offsup_seq
  import offsup_pkg::*;
#(
  parameter int TEMP_W       = 8,
  parameter int TRIP_CODE    = 150,
  parameter int RELEASE_CODE = 110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vcc_above_start,
  input  logic              vcc_below_uvlo,
  input  logic              vcc_over_limit,
  input  logic              bo_above_ref,
  input  logic              ref_ok,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              startup_en,
  output logic              pwm_en,
  output logic              gate_pulldown,
  output logic              bo_hyst_en,
  output logic              logic_rst
);

  sq_state_t state;
  logic can_start, must_drop;
  logic st_lock, st_rst, st_run;
  logic ovp_q, therm_q;

  assign can_start = vcc_above_start & ~vcc_below_uvlo & ref_ok;
  assign must_drop = vcc_below_uvlo | ~ref_ok;

  offsup_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .can_start(can_start),
    .must_drop(must_drop), .state(state)
  );

  assign st_lock = (state == SQ_LOCK);
  assign st_rst  = (state == SQ_RST);
  assign st_run  = (state == SQ_RUN);

  offsup_ovp_latch u_ovp (
    .clk(clk), .rst_n(rst_n), .clr(st_lock),
    .set(vcc_over_limit), .q(ovp_q)
  );

  offsup_therm #(
    .TEMP_W(TEMP_W), .TRIP_CODE(TRIP_CODE), .RELEASE_CODE(RELEASE_CODE)
  ) u_therm (
    .clk(clk), .rst_n(rst_n), .code(temp_code), .hot(therm_q)
  );

  assign startup_en    = ~st_run;
  assign gate_pulldown = ~st_run;
  assign logic_rst     = st_rst;
  assign bo_hyst_en    = bo_above_ref;
  assign pwm_en        = st_run & ~ovp_q & ~vcc_over_limit & bo_above_ref & ~therm_q;

endmodule

// File: rtl/offsup_seq_chk.sv
module offsup_seq_chk #(
  parameter int TEMP_W       = 8,
  parameter int RELEASE_CODE = 110
) (
  input logic              clk,
  input logic              rst_n,
  input logic              startup_en,
  input logic              pwm_en,
  input logic              gate_pulldown,
  input logic              bo_hyst_en,
  input logic              logic_rst,
  input logic              vcc_below_uvlo,
  input logic              ref_ok,
  input logic [TEMP_W-1:0] temp_code,
  input logic              st_lock,
  input logic              st_run,
  input logic              ovp_q,
  input logic              therm_q
);

  // R1
  lock_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_lock |-> (startup_en && gate_pulldown && !pwm_en));

  // R2
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    logic_rst |=> !logic_rst);

  // R2
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_run) |-> $past(logic_rst));

  // R4
  drop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_run && (vcc_below_uvlo || !ref_ok)) |=> st_lock);

  // R5
  ovp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_q && !st_lock) |=> ovp_q);

  // R5
  ovp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_q |-> !pwm_en);

  // R7
  hyst_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en |-> bo_hyst_en);

  // R8
  therm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_q && (temp_code > TEMP_W'(RELEASE_CODE))) |=> therm_q);

  // R8
  therm_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    therm_q |-> !pwm_en);

endmodule

bind offsup_seq offsup_seq_chk #(.TEMP_W(TEMP_W), .RELEASE_CODE(RELEASE_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .startup_en(startup_en), .pwm_en(pwm_en),
  .gate_pulldown(gate_pulldown), .bo_hyst_en(bo_hyst_en), .logic_rst(logic_rst),
  .vcc_below_uvlo(vcc_below_uvlo), .ref_ok(ref_ok), .temp_code(temp_code),
  .st_lock(st_lock), .st_run(st_run), .ovp_q(ovp_q), .therm_q(therm_q)
);

// File: tb/tb_offsup_seq.sv
module tb_offsup_seq;

  localparam int TW  = 4;
  localparam int TRP = 12;
  localparam int REL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above_start = 1'b0, below_uvlo = 1'b1, over_lim = 1'b0, bo = 1'b1, refok = 1'b1;
  logic [TW-1:0] temp = '0;
  logic startup_en, pwm_en, gate_pulldown, bo_hyst_en, logic_rst;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  offsup_seq #(.TEMP_W(TW), .TRIP_CODE(TRP), .RELEASE_CODE(REL)) dut (
    .clk(clk), .rst_n(rst_n), .vcc_above_start(above_start), .vcc_below_uvlo(below_uvlo),
    .vcc_over_limit(over_lim), .bo_above_ref(bo), .ref_ok(refok), .temp_code(temp),
    .startup_en(startup_en), .pwm_en(pwm_en), .gate_pulldown(gate_pulldown),
    .bo_hyst_en(bo_hyst_en), .logic_rst(logic_rst)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // Reference model of the thermal flag, written as a band test.
  function automatic logic tmodel(input logic cur, input int t);
    logic r;
    r = cur;
    if (t >= TRP) r = 1'b1;
    if (t <= REL) r = 1'b0;
    return r;
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic m;
    repeat (3) step();
    // R9 reset state, R1 lockout outputs
    check("R9 logic_rst", logic_rst, 1'b0);
    check("R1 startup_en", startup_en, 1'b1);
    check("R1 gate_pulldown", gate_pulldown, 1'b1);
    check("R1 pwm_en", pwm_en, 1'b0);
    rst_n = 1'b1;
    step();

    // R2 exit condition sweep from lockout
    for (int i = 0; i < 8; i++) begin
      above_start = i[0];
      below_uvlo  = i[1];
      refok       = i[2];
      step();
      check("R2 exit", logic_rst, i[0] & ~i[1] & i[2]);
      check("R2 pwm off", pwm_en, 1'b0);
      above_start = 1'b0; below_uvlo = 1'b1; refok = 1'b1;
      step();
      step();
      check("R1 back in lockout", startup_en, 1'b1);
    end

    // R2/R3 power-up
    above_start = 1'b1; below_uvlo = 1'b0; refok = 1'b1;
    step();
    check("R2 reset pulse", logic_rst, 1'b1);
    check("R2 startup during reset", startup_en, 1'b1);
    check("R2 pwm during reset", pwm_en, 1'b0);
    step();
    check("R2 single pulse", logic_rst, 1'b0);
    check("R3 pwm_en", pwm_en, 1'b1);
    check("R3 startup_en", startup_en, 1'b0);
    check("R3 gate_pulldown", gate_pulldown, 1'b0);

    // R6 / R7 mains sense
    bo = 1'b0; #1;
    check("R6 pwm gated", pwm_en, 1'b0);
    check("R7 hyst off", bo_hyst_en, 1'b0);
    step();
    check("R6 still running", startup_en, 1'b0);
    check("R6 pwm gated held", pwm_en, 1'b0);
    bo = 1'b1; #1;
    check("R6 pwm resumes", pwm_en, 1'b1);
    check("R7 hyst on", bo_hyst_en, 1'b1);

    // R8 thermal ramp up and down over all codes
    m = 1'b0;
    for (int k = 0; k < 32; k++) begin
      int t;
      t = (k < 16) ? k : 31 - k;
      temp = TW'(t);
      step();
      m = tmodel(m, t);
      check("R8 thermal gate", pwm_en, ~m);
    end

    // R5 overvoltage latch
    over_lim = 1'b1; #1;
    check("R5 immediate", pwm_en, 1'b0);
    step();
    over_lim = 1'b0;
    step();
    check("R5 latched", pwm_en, 1'b0);
    check("R5 still run", startup_en, 1'b0);
    below_uvlo = 1'b1; above_start = 1'b0;
    step();
    check("R4 uvlo lockout", startup_en, 1'b1);
    check("R1 pulldown", gate_pulldown, 1'b1);
    below_uvlo = 1'b0; above_start = 1'b1;
    step();
    check("R2 restart pulse", logic_rst, 1'b1);
    step();
    check("R5 cleared by lockout", pwm_en, 1'b1);

    // R4 reference drop
    refok = 1'b0;
    step();
    check("R4 ref drop", startup_en, 1'b1);
    check("R4 ref drop pwm", pwm_en, 1'b0);
    refok = 1'b1;
    step();
    check("R2 pulse after ref", logic_rst, 1'b1);
    step();
    check("R3 run again", pwm_en, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule